// File: doc/BRIEF.md
# Channel Packet Formatter

This block is the per-channel formatter of a multi-channel receiver. It takes a one-bit serial stream from a down-converter and rebuilds it, one bit per clock, into 32-bit words. Each word carries one complex sample, with I in the upper half and Q in the lower half. It groups the words into packets. Each packet opens with three header words: the channel identity, a running block number, and a timestamp latched from a live time code. A host-set number of sample words follows the header. Every packet word goes out on an output FIFO write port. A one-cycle ready pulse then tells the downstream transfer controller that a whole packet is in the FIFO.

A sync strobe, when enabled, makes the formatter overwrite the next two accepted samples with a fixed two-word marker. The receiving software uses the marker to align to an external event. The host also loads a routing code and a destination address, which the formatter drives straight out to the transfer controller. The host write port is a simple select/data/strobe register interface.

Top module: `chan_packetizer`

## Requirements
- R1: A cycle with `ser_frame` high loads `ser_data` as bit 31 of a new word, and the next 31 cycles supply bits 30 down to 0 (MSB first). Bits [31:16] are I and bits [15:0] are Q. The word is accepted on the clock edge after bit 0. A frame strobe before a word is complete throws away the partial word and starts again.
- R2: A packet is written as the channel ID word, the block number word, the timestamp word, and then N sample words. N is the sample-count register (select 2, legal values 1 and up, reset value 4). The channel ID register is select 0.
- R3: The timestamp word equals the `timestamp` input as seen on the clock edge that accepts the packet's first sample.
- R4: The block number goes up by one after each completed packet and wraps from 0xFFFFFFFF to 0. A host write to select 1 reloads it, and wins over an increment in the same cycle.
- R5: With `sync_en` high, a `sync_strobe` pulse replaces the next two accepted samples with 0xA5A5A5A5 and then 0x5A5A5A5A. Both still count toward N, and the pair may straddle a packet boundary. A sample accepted on the strobe's own edge is not replaced.
- R6: With `sync_en` low, `sync_strobe` has no effect on the written data.
- R7: A word due to be written on an edge where `fifo_full` is high is not written, and `overrun` is set. `overrun` stays set until reset. Sample counting and packet completion carry on as normal.
- R8: `pkt_ready` is high for exactly one cycle, in the cycle after the packet's last sample word was written (or dropped).
- R9: Host writes to select 3 and select 4 load `route_code` and `route_addr`. These outputs change only after a host write.
- R10: After reset `fifo_wr`, `pkt_ready` and `overrun` are 0, `route_code` and `route_addr` are 0, and the block number is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_data | input | 1 | Serial sample bit |
| ser_frame | input | 1 | Marks the MSB of a serial word |
| sync_en | input | 1 | Enables sync marker insertion |
| sync_strobe | input | 1 | Sync event pulse |
| timestamp | input | 32 | Live time code |
| cfg_we | input | 1 | Host register write strobe |
| cfg_sel | input | 3 | Host register select |
| cfg_wdata | input | 32 | Host write data |
| fifo_full | input | 1 | Output FIFO full |
| fifo_wr | output | 1 | Output FIFO write enable |
| fifo_data | output | 32 | Output FIFO write data |
| pkt_ready | output | 1 | Packet complete pulse |
| overrun | output | 1 | Sticky dropped-word flag |
| route_code | output | 32 | Routing code for the transfer controller |
| route_addr | output | 32 | Destination address for the transfer controller |

## Verification
A wrong deserializer bit count or a misplaced frame restart corrupts the first sample word written, four cycles after its acceptance edge. A wrong packet index shows up within one packet: the header appears in the wrong place, or `pkt_ready` pulses at the wrong time. A stale block counter or sync countdown stays hidden until the next header or the next two samples. For that reason the stimulus crosses packet boundaries with a sync pair pending, and checks the block word across a wrap.

// File: rtl/chan_packetizer.sv
module chan_packetizer #(
  parameter int CNT_W = 12,
  parameter logic [CNT_W-1:0] SAMPLES_RST = 4,
  parameter logic [31:0] CHAN_RST = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_data,
  input  logic        ser_frame,
  input  logic        sync_en,
  input  logic        sync_strobe,
  input  logic [31:0] timestamp,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        fifo_full,
  output logic        fifo_wr,
  output logic [31:0] fifo_data,
  output logic        pkt_ready,
  output logic        overrun,
  output logic [31:0] route_code,
  output logic [31:0] route_addr
);
  localparam logic [CNT_W-1:0] ONE = 1;
  localparam logic [31:0] SYNC_A = 32'hA5A5A5A5;
  localparam logic [31:0] SYNC_B = 32'h5A5A5A5A;

  typedef enum logic [2:0] {IDLE, H_ID, H_BLK, H_TS, H_S0, BODY} st_t;

  st_t st;
  logic [31:0] sh, hold, ts_q, chan_id, blk;
  logic [5:0]  bitc;
  logic [1:0]  sync_left;
  logic [CNT_W-1:0] idx, nsamp;
  logic        emit, done, done_d;
  logic [31:0] wdat;

  wire samp_vld = (bitc == 6'd32);
  wire [31:0] word = (sync_left == 2'd2) ? SYNC_A :
                     (sync_left == 2'd1) ? SYNC_B : sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0;
      bitc <= '0;
    end else if (ser_frame) begin
      sh <= {31'b0, ser_data};
      bitc <= 6'd1;
    end else if (bitc != 6'd0 && bitc < 6'd32) begin
      sh <= {sh[30:0], ser_data};
      bitc <= bitc + 6'd1;
    end else begin
      bitc <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sync_left <= '0;
    else if (sync_en && sync_strobe) sync_left <= 2'd2;
    else if (samp_vld && sync_left != 2'd0) sync_left <= sync_left - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_id <= CHAN_RST;
      nsamp <= SAMPLES_RST;
      route_code <= '0;
      route_addr <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: chan_id <= cfg_wdata;
        3'd2: nsamp <= cfg_wdata[CNT_W-1:0];
        3'd3: route_code <= cfg_wdata;
        3'd4: route_addr <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) blk <= '0;
    else if (cfg_we && cfg_sel == 3'd1) blk <= cfg_wdata;
    else if (done) blk <= blk + 32'd1;
  end

  assign done = (st == H_S0 && idx == nsamp) ||
                (st == BODY && samp_vld && (idx + ONE) == nsamp);

  always_comb begin
    emit = 1'b1;
    wdat = word;
    case (st)
      H_ID:  wdat = chan_id;
      H_BLK: wdat = blk;
      H_TS:  wdat = ts_q;
      H_S0:  wdat = hold;
      BODY:  emit = samp_vld;
      default: emit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      idx <= '0;
      hold <= '0;
      ts_q <= '0;
    end else begin
      case (st)
        IDLE: if (samp_vld) begin
          st <= H_ID;
          idx <= ONE;
          hold <= word;
          ts_q <= timestamp;
        end
        H_ID:  st <= H_BLK;
        H_BLK: st <= H_TS;
        H_TS:  st <= H_S0;
        H_S0:  st <= done ? IDLE : BODY;
        BODY: if (samp_vld) begin
          idx <= idx + ONE;
          if (done) st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_wr <= 1'b0;
      fifo_data <= '0;
      overrun <= 1'b0;
      done_d <= 1'b0;
      pkt_ready <= 1'b0;
    end else begin
      fifo_wr <= emit && !fifo_full;
      if (emit) fifo_data <= wdat;
      overrun <= overrun || (emit && fifo_full);
      done_d <= done;
      pkt_ready <= done_d;
    end
  end
endmodule

// File: rtl/chan_packetizer_chk.sv
module chan_packetizer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        fifo_full,
  input logic        fifo_wr,
  input logic        pkt_ready,
  input logic        overrun,
  input logic [31:0] route_code,
  input logic [31:0] route_addr
);
  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |=> !pkt_ready);
  // R8
  ready_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> $past(fifo_wr || overrun));
  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R7
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(fifo_full));
  // R7
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(!fifo_full));
  // R9
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> ($stable(route_code) && $stable(route_addr)));
endmodule

bind chan_packetizer chan_packetizer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .fifo_full(fifo_full),
  .fifo_wr(fifo_wr), .pkt_ready(pkt_ready), .overrun(overrun),
  .route_code(route_code), .route_addr(route_addr)
);

// File: tb/chan_packetizer_bench.sv
module chan_packetizer_bench;
  logic clk = 0, rst_n = 0, ser_data = 0, ser_frame = 0;
  logic sync_en = 0, sync_strobe = 0, cfg_we = 0, fifo_full = 0;
  logic [2:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0, timestamp = 0;
  logic fifo_wr, pkt_ready, overrun;
  logic [31:0] fifo_data, route_code, route_addr;

  always #5 clk = ~clk;

  chan_packetizer u_chan_packetizer (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_frame(ser_frame),
    .sync_en(sync_en), .sync_strobe(sync_strobe), .timestamp(timestamp),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .pkt_ready(pkt_ready), .overrun(overrun),
    .route_code(route_code), .route_addr(route_addr));

  int nchk = 0, nfail = 0, ncap = 0, nexp = 0, npkt = 0;
  bit finished = 0;
  logic [31:0] cap [256];
  logic [31:0] expq [256];
  logic prev_wr = 0;

  logic [31:0] m_id, m_blk, m_ts;
  int m_idx = 0, m_n = 4, m_sync = 0;

  // {strobe before sample, sample, timestamp}
  localparam logic [64:0] VEC [12] = '{
    {1'b0, 32'h1234_ABCD, 32'h0000_1000}, {1'b0, 32'h8001_7FFE, 32'h0000_1001},
    {1'b0, 32'hFFFF_0000, 32'h0000_1002}, {1'b1, 32'h0F0F_F0F0, 32'h0000_1003},
    {1'b0, 32'hDEAD_BEEF, 32'h0000_2000}, {1'b0, 32'h0000_0001, 32'h0000_2001},
    {1'b0, 32'h8000_0000, 32'h0000_2002}, {1'b0, 32'h1357_9BDF, 32'h0000_2003},
    {1'b0, 32'h2468_ACE0, 32'h0000_3000}, {1'b1, 32'hCAFE_F00D, 32'h0000_3001},
    {1'b0, 32'h7777_8888, 32'h0000_3002}, {1'b0, 32'h0102_0304, 32'h0000_3003}};

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (fifo_wr) begin cap[ncap] = fifo_data; ncap++; end
    if (pkt_ready) begin
      npkt++;
      chk("R8 ready follows last word", {31'b0, prev_wr || overrun}, 32'd1);
    end
    prev_wr = fifo_wr;
  end

  task automatic cfg(logic [2:0] s, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic mpush(logic [31:0] w);
    expq[nexp] = w; nexp++;
  endtask

  task automatic mstep(logic [31:0] d, logic [31:0] ts, bit full);
    logic [31:0] w;
    if (m_idx == 0) begin mpush(m_id); mpush(m_blk); mpush(ts); end
    w = (m_sync == 2) ? 32'hA5A5A5A5 : (m_sync == 1) ? 32'h5A5A5A5A : d;
    if (m_sync != 0) m_sync--;
    if (!full) mpush(w);
    m_idx++;
    if (m_idx == m_n) begin m_idx = 0; m_blk++; end
  endtask

  task automatic send(logic [31:0] d, logic [31:0] ts, bit strb, bit full);
    if (strb) begin
      @(negedge clk); sync_strobe = 1;
      @(negedge clk); sync_strobe = 0;
      if (sync_en) m_sync = 2;
    end
    timestamp = ts; fifo_full = full;
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk); ser_frame = (i == 31); ser_data = d[i];
    end
    @(negedge clk); ser_frame = 0; ser_data = 0;
    @(negedge clk); fifo_full = 0;
    repeat (5) @(negedge clk);
    mstep(d, ts, full);
  endtask

  task automatic compare(string r);
    repeat (8) @(negedge clk);
    chk({r, " word count"}, ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++) chk(r, cap[i], expq[i]);
    ncap = 0; nexp = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 fifo_wr", {31'b0, fifo_wr}, 0);
    chk("R10 pkt_ready", {31'b0, pkt_ready}, 0);
    chk("R10 overrun", {31'b0, overrun}, 0);
    chk("R10 route_code", route_code, 0);
    chk("R10 route_addr", route_addr, 0);

    // R9 routing registers
    cfg(3'd3, 32'h0000_00A7); cfg(3'd4, 32'hC000_1F40);
    chk("R9 route_code", route_code, 32'h0000_00A7);
    chk("R9 route_addr", route_addr, 32'hC000_1F40);

    m_id = 32'h0000_0C07; m_blk = 32'h10;
    cfg(3'd0, m_id); cfg(3'd1, m_blk);
    sync_en = 1;
    // R1 R2 R3 R4 R5: table walk, sync pairs straddle packet boundaries
    for (int v = 0; v < 12; v++) send(VEC[v][63:32], VEC[v][31:0], VEC[v][64], 0);
    compare("R2 R5 packet stream");
    chk("R8 packet count", npkt, 3);

    // R6 strobe ignored while disabled
    sync_en = 0;
    send(32'hAAAA_5555, 32'h4000, 1, 0);
    send(32'h3333_CCCC, 32'h4001, 0, 0);
    send(32'h1111_2222, 32'h4002, 1, 0);
    send(32'h9999_0000, 32'h4003, 0, 0);
    compare("R6 sync disabled");

    // R7 full drops a word, overrun sticky, packet still completes
    send(32'h0000_0011, 32'h5000, 0, 0);
    send(32'h0000_0022, 32'h5001, 0, 1);
    chk("R7 overrun set", {31'b0, overrun}, 1);
    send(32'h0000_0033, 32'h5002, 0, 0);
    send(32'h0000_0044, 32'h5003, 0, 0);
    compare("R7 dropped word");
    chk("R7 overrun sticky", {31'b0, overrun}, 1);
    chk("R8 packet count after drop", npkt, 5);

    // R4 wrap with one-sample packets; R1 frame restart drops partial word
    cfg(3'd2, 32'd1); m_n = 1;
    cfg(3'd1, 32'hFFFF_FFFF); m_blk = 32'hFFFF_FFFF;
    for (int i = 9; i >= 0; i--) begin
      @(negedge clk); ser_frame = (i == 9); ser_data = 1'b1;
    end
    send(32'h4321_8765, 32'h6000, 0, 0);
    send(32'h00FF_FF00, 32'h6001, 0, 0);
    compare("R4 R1 wrap and restart");
    chk("R8 packet count final", npkt, 7);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule